// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block turns a reference clock into a slower sample-rate enable whose long-run frequency is an exact rational fraction of the reference. Two 12-bit words set the fraction. The increment `inc_i` plays the role of L and the trim `trim_i` plays the role of M. The output rate is inc / (4096 − trim + inc) of the input rate. Each output period is one of two neighbouring whole numbers of input cycles, and the two lengths are mixed so that the average is exact. For example, a 2/9 setting gives periods of 4 and 5 cycles in equal numbers.

The block uses a phase accumulator. The accumulator adds the increment on every input cycle, with a modulus one bit wider than the words, and each wrap produces a one-cycle tick. The block also drives a divided clock that stays high while the phase is in the lower half of its range. A bypass select forces the tick high on every cycle and passes the input clock straight to the divided-clock output. New words are adopted only at a wrap, so the period in progress is never corrupted.

Top module: `frac_clk_div`

## Requirements
- R1: With constant words, exactly inc ticks appear in every window of N = 4096 − trim + inc input cycles that starts at a phase of zero.
- R2: The spacing between consecutive ticks is always floor(N/inc) or ceil(N/inc) input cycles.
- R3: `rst_i` is active high and synchronous. While it is held, `tick_o` = 0 and `div_clk_o` = 0. Reset installs the words inc = 256 and trim = 1563, so the first tick after release comes on the 11th cycle.
- R4: If `bypass_i` is sampled high at two consecutive edges, `tick_o` is 1 after the second of them and stays 1 while the select stays high. While bypassed, `div_clk_o` follows `clk_i`.
- R5: An active increment of 0 produces no ticks. In that state the words on the inputs are adopted on every cycle, so a nonzero increment restarts ticking without a bypass.
- R6: Changes on `inc_i` and `trim_i` take effect only at a tick. The period in progress completes with the old words.
- R7: With inc = 1, `div_clk_o` is high for ceil(N/2) of every N cycles.
- R8: The phase stays below the modulus. Leaving bypass restarts the phase at 0, so the first tick comes after ceil(N/inc) cycles.
- R9: The modulus is held in 13 bits. The extreme setting inc = 4095, trim = 0 (N = 8191) still yields 4095 ticks per 8191 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous reset, active high |
| bypass_i | input | 1 | 1 = bypass the divider |
| inc_i | input | 12 | Phase increment (L) |
| trim_i | input | 12 | Modulus trim (M) |
| tick_o | output | 1 | One-cycle output enable |
| div_clk_o | output | 1 | Divided clock, or the input clock in bypass |

## Verification
The bound checker watches four properties on every cycle. The phase must stay below the active modulus. Bypass must force a tick. A zero increment must never tick. The active words may change only at a tick, while idle or while bypassed. Whether the rate is exact, which two spacings appear, the duty of the divided clock, the reset defaults and the 13-bit extreme all need long windows of cycles. Those are shown only by the bench, which counts ticks and gaps per setting over whole modulus windows.

// File: rtl/fdiv_pkg.sv
`timescale 1ns/1ps
package fdiv_pkg;
    localparam int unsigned FD_CNT_W = 12;
    localparam int unsigned FD_INC_DEF = 256;
    localparam int unsigned FD_TRIM_DEF = 1563;

    typedef enum logic [1:0] {
        FD_RUN    = 2'd0,
        FD_IDLE   = 2'd1,
        FD_BYPASS = 2'd2
    } fd_mode_e;
endpackage

// File: rtl/fdiv_cfg.sv
`timescale 1ns/1ps
module fdiv_cfg #(
    parameter int unsigned CNT_W    = 12,
    parameter int unsigned INC_RST  = 256,
    parameter int unsigned TRIM_RST = 1563
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             bypass_i,
    input  logic [CNT_W-1:0] inc_i,
    input  logic [CNT_W-1:0] trim_i,
    input  logic             load_i,
    output logic             byp_o,
    output logic [CNT_W-1:0] inc_o,
    output logic [CNT_W-1:0] trim_o,
    output logic [CNT_W:0]   mod_o,
    output logic [CNT_W:0]   mod_new_o
);
    localparam int unsigned MOD_W = CNT_W + 1;
    localparam logic [MOD_W-1:0] FULL = {1'b1, {CNT_W{1'b0}}};

    typedef struct packed {
        logic             byp;
        logic [CNT_W-1:0] inc;
        logic [CNT_W-1:0] trim;
        logic [MOD_W-1:0] modv;
    } cfg_s;

    cfg_s cfg_d, cfg_q;
    logic [MOD_W-1:0] mod_new;

    function automatic logic [MOD_W-1:0] mod_of(input logic [CNT_W-1:0] l,
                                                 input logic [CNT_W-1:0] m);
        return FULL - {1'b0, m} + {1'b0, l};
    endfunction

    always_comb begin
        mod_new = mod_of(inc_i, trim_i);
        cfg_d   = cfg_q;
        cfg_d.byp = bypass_i;
        if (load_i) begin
            cfg_d.inc  = inc_i;
            cfg_d.trim = trim_i;
            cfg_d.modv = mod_new;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q.byp  <= 1'b0;
            cfg_q.inc  <= CNT_W'(INC_RST);
            cfg_q.trim <= CNT_W'(TRIM_RST);
            cfg_q.modv <= mod_of(CNT_W'(INC_RST), CNT_W'(TRIM_RST));
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign byp_o     = cfg_q.byp;
    assign inc_o     = cfg_q.inc;
    assign trim_o    = cfg_q.trim;
    assign mod_o     = cfg_q.modv;
    assign mod_new_o = mod_new;
endmodule

// File: rtl/fdiv_accum.sv
`timescale 1ns/1ps
module fdiv_accum
    import fdiv_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             byp_i,
    input  logic [CNT_W-1:0] inc_i,
    input  logic [CNT_W:0]   mod_i,
    input  logic [CNT_W:0]   mod_new_i,
    output logic             load_o,
    output logic             tick_o,
    output logic [CNT_W:0]   acc_o
);
    localparam int unsigned MOD_W = CNT_W + 1;
    localparam int unsigned SUM_W = MOD_W + 1;

    typedef struct packed {
        logic [MOD_W-1:0] acc;
        logic             tick;
    } acc_s;

    acc_s       st_d, st_q;
    fd_mode_e   mode;
    logic [SUM_W-1:0] sum;
    logic [MOD_W-1:0] rem;
    logic             wrap;

    always_comb begin
        sum  = SUM_W'(st_q.acc) + SUM_W'(inc_i);
        wrap = (sum >= SUM_W'(mod_i));
        rem  = MOD_W'(sum - SUM_W'(mod_i));

        if (byp_i)
            mode = FD_BYPASS;
        else if ((inc_i == '0) || (MOD_W'(inc_i) >= mod_i))
            mode = FD_IDLE;
        else
            mode = FD_RUN;

        st_d   = st_q;
        load_o = 1'b0;
        unique case (mode)
            FD_BYPASS: begin
                st_d.acc  = '0;
                st_d.tick = 1'b1;
                load_o    = 1'b1;
            end
            FD_IDLE: begin
                st_d.acc  = '0;
                st_d.tick = 1'b0;
                load_o    = 1'b1;
            end
            default: begin
                if (wrap) begin
                    st_d.tick = 1'b1;
                    load_o    = 1'b1;
                    // residue kept; cleared only if it no longer fits the new modulus
                    st_d.acc  = (rem >= mod_new_i) ? '0 : rem;
                end else begin
                    st_d.tick = 1'b0;
                    st_d.acc  = sum[MOD_W-1:0];
                end
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.acc  <= '0;
            st_q.tick <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;
    assign acc_o  = st_q.acc;
endmodule

// File: rtl/fdiv_clkout.sv
`timescale 1ns/1ps
module fdiv_clkout #(
    parameter int unsigned CNT_W = 12
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           byp_i,
    input  logic [CNT_W:0] acc_i,
    input  logic [CNT_W:0] mod_i,
    output logic           div_clk_o
);
    localparam int unsigned SUM_W = CNT_W + 2;

    logic lvl_d, lvl_q;
    logic [SUM_W-1:0] half;

    always_comb begin
        half  = (SUM_W'(mod_i) + SUM_W'(1)) >> 1;
        lvl_d = (SUM_W'(acc_i) < half);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) lvl_q <= 1'b0;
        else       lvl_q <= lvl_d;
    end

    assign div_clk_o = byp_i ? clk_i : lvl_q;
endmodule

// File: rtl/frac_clk_div.sv
`timescale 1ns/1ps
module frac_clk_div
    import fdiv_pkg::*;
#(
    parameter int unsigned CNT_W    = FD_CNT_W,
    parameter int unsigned INC_RST  = FD_INC_DEF,
    parameter int unsigned TRIM_RST = FD_TRIM_DEF
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             bypass_i,
    input  logic [CNT_W-1:0] inc_i,
    input  logic [CNT_W-1:0] trim_i,
    output logic             tick_o,
    output logic             div_clk_o
);
    localparam int unsigned MOD_W = CNT_W + 1;

    logic             byp_w;
    logic             load_w;
    logic [CNT_W-1:0] act_inc_w;
    logic [CNT_W-1:0] act_trim_w;
    logic [MOD_W-1:0] mod_w;
    logic [MOD_W-1:0] mod_new_w;
    logic [MOD_W-1:0] acc_w;

    fdiv_cfg #(.CNT_W(CNT_W), .INC_RST(INC_RST), .TRIM_RST(TRIM_RST)) u_cfg (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .bypass_i  (bypass_i),
        .inc_i     (inc_i),
        .trim_i    (trim_i),
        .load_i    (load_w),
        .byp_o     (byp_w),
        .inc_o     (act_inc_w),
        .trim_o    (act_trim_w),
        .mod_o     (mod_w),
        .mod_new_o (mod_new_w)
    );

    fdiv_accum #(.CNT_W(CNT_W)) u_accum (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .byp_i     (byp_w),
        .inc_i     (act_inc_w),
        .mod_i     (mod_w),
        .mod_new_i (mod_new_w),
        .load_o    (load_w),
        .tick_o    (tick_o),
        .acc_o     (acc_w)
    );

    fdiv_clkout #(.CNT_W(CNT_W)) u_clkout (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .byp_i     (byp_w),
        .acc_i     (acc_w),
        .mod_i     (mod_w),
        .div_clk_o (div_clk_o)
    );
endmodule

// File: rtl/fdiv_checker.sv
`timescale 1ns/1ps
module fdiv_checker #(
    parameter int unsigned CNT_W = 12
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             tick_o,
    input logic             byp_q,
    input logic [CNT_W-1:0] act_inc,
    input logic [CNT_W-1:0] act_trim,
    input logic [CNT_W:0]   acc,
    input logic [CNT_W:0]   modv
);
    assert_phase_bound_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        acc < modv);

    assert_bypass_tick_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(byp_q) |-> tick_o);

    assert_idle_quiet_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!byp_q && act_inc == '0) |=> !tick_o);

    assert_load_at_tick_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (act_inc != $past(act_inc) || act_trim != $past(act_trim))
        |-> (tick_o || $past(act_inc) == '0 || $past(byp_q)));
endmodule

bind frac_clk_div fdiv_checker #(.CNT_W(CNT_W)) u_fdiv_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .tick_o   (tick_o),
    .byp_q    (byp_w),
    .act_inc  (act_inc_w),
    .act_trim (act_trim_w),
    .acc      (acc_w),
    .modv     (mod_w)
);

// File: tb/frac_clk_div_tb.sv
`timescale 1ns/1ps
module frac_clk_div_tb;
    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic        bypass_i = 1'b0;
    logic [11:0] inc_i = '0;
    logic [11:0] trim_i = '0;
    logic        tick_o;
    logic        div_clk_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk_i = ~clk_i;

    frac_clk_div u_dut (
        .clk_i(clk_i), .rst_i(rst_i), .bypass_i(bypass_i),
        .inc_i(inc_i), .trim_i(trim_i), .tick_o(tick_o), .div_clk_o(div_clk_o)
    );

    // {inc, trim, ticks per window, min gap, max gap}
    localparam int NV = 8;
    localparam logic [62:0] VEC [NV] = '{
        {12'd2,    12'd4087, 13'd2,    13'd5,    13'd6},
        {12'd2,    12'd4089, 13'd2,    13'd4,    13'd5},
        {12'd1,    12'd4095, 13'd1,    13'd2,    13'd2},
        {12'd3,    12'd4095, 13'd3,    13'd1,    13'd2},
        {12'd100,  12'd4095, 13'd100,  13'd1,    13'd2},
        {12'd1,    12'd0,    13'd1,    13'd4097, 13'd4097},
        {12'd4095, 12'd0,    13'd4095, 13'd2,    13'd3},
        {12'd256,  12'd1563, 13'd256,  13'd10,   13'd11}
    };

    task automatic cyc();
        @(posedge clk_i);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_cfg(input int l, input int m);
        inc_i = 12'(l);
        trim_i = 12'(m);
        bypass_i = 1'b1;
        cyc();
        bypass_i = 1'b0;
        cyc();
    endtask

    task automatic run_window(input int n, output int ticks, output int gmin,
                              output int gmax, output int gfirst, output int highs);
        int since = 0;
        ticks = 0; gmin = 1 << 30; gmax = 0; gfirst = 0; highs = 0;
        for (int i = 0; i < n; i++) begin
            cyc();
            since++;
            if (div_clk_o) highs++;
            if (tick_o) begin
                ticks++;
                if (ticks == 1) gfirst = since;
                if (since < gmin) gmin = since;
                if (since > gmax) gmax = since;
                since = 0;
            end
        end
    endtask

    task automatic gap_to_tick(output int g);
        g = 0;
        for (int i = 0; i < 10000; i++) begin
            cyc();
            g++;
            if (tick_o) break;
        end
    endtask

    initial begin
        int t, gmin, gmax, gfirst, highs, g;
        // R3: reset state and defaults
        inc_i = 12'd1; trim_i = 12'd0;
        repeat (3) cyc();
        check(tick_o == 1'b0, "R3 tick in reset", int'(tick_o), 0);
        check(div_clk_o == 1'b0, "R3 div clock in reset", int'(div_clk_o), 0);
        rst_i = 1'b0;
        gap_to_tick(g);
        check(g == 11, "R3 first tick with default words", g, 11);

        // vector table: R1, R2, R8 (R9 on the 13-bit extreme)
        for (int v = 0; v < NV; v++) begin
            int l, m, n, et, emin, emax;
            l = int'(VEC[v][62:51]);
            m = int'(VEC[v][50:39]);
            et = int'(VEC[v][38:26]);
            emin = int'(VEC[v][25:13]);
            emax = int'(VEC[v][12:0]);
            n = 4096 - m + l;
            load_cfg(l, m);
            run_window(n, t, gmin, gmax, gfirst, highs);
            check(t == et, (v == 6) ? "R9 tick count" : "R1 tick count", t, et);
            check(gmin >= emin && gmax <= emax, "R2 gap range (max shown)", gmax, emax);
            check(gfirst == emax, "R8 first gap after bypass", gfirst, emax);
        end

        // R4: bypass
        bypass_i = 1'b1;
        cyc(); cyc();
        for (int i = 0; i < 4; i++) begin
            check(tick_o == 1'b1, "R4 tick in bypass", int'(tick_o), 1);
            check(div_clk_o == 1'b1, "R4 div clock high phase", int'(div_clk_o), 1);
            @(negedge clk_i); #1;
            check(div_clk_o == 1'b0, "R4 div clock low phase", int'(div_clk_o), 0);
            cyc();
        end
        bypass_i = 1'b0;

        // R5: zero increment stays silent, then restarts without bypass
        load_cfg(0, 100);
        run_window(50, t, gmin, gmax, gfirst, highs);
        check(t == 0, "R5 no tick with zero increment", t, 0);
        inc_i = 12'd2; trim_i = 12'd4087;
        cyc();
        run_window(11, t, gmin, gmax, gfirst, highs);
        check(t == 2, "R5 restart from idle", t, 2);

        // R6: new words only at a tick
        load_cfg(1, 4087);
        gap_to_tick(g);
        trim_i = 12'd4091;
        gap_to_tick(g);
        check(g == 10, "R6 period in progress keeps old words", g, 10);
        gap_to_tick(g);
        check(g == 6, "R6 new words after tick", g, 6);

        // R7: duty of divided clock with inc = 1
        load_cfg(1, 4087);
        run_window(10, t, gmin, gmax, gfirst, highs);
        check(highs == 5, "R7 high cycles N=10", highs, 5);
        load_cfg(1, 4086);
        run_window(11, t, gmin, gmax, gfirst, highs);
        check(highs == 6, "R7 high cycles N=11", highs, 6);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk_i);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule